// File: doc/BRIEF.md
# Accumulator Logical Right Shifter

This block is the shift stage of a 40-bit multiply-accumulate datapath. It holds a 40-bit accumulator and, when started, moves its contents toward the least significant end by a count taken from the low five bits of an operand. Zeros enter at the top. The count is treated as unsigned. One bit position is processed per clock, so a shift by k occupies the block for k cycles and then one more cycle in which the result and its status flags are presented with a done pulse.

When the shift finishes, the block updates six status flags:

- **N** copies the top bit of the result.
- **Z** marks an all-zero result.
- **C** is always forced low.
- **E** reports that the guard bits above bit 31 carry information beyond a sign extension of bit 31.
- **SV** and **SL** are left exactly as they were.

There is no saturation of any kind. A count above 8 is outside the legal range. For such a count the block moves nothing and keeps its flags, but it still completes with done and an illegal-count indication.

The controller has three states:

- **IDLE**: the block accepts either a start or a load.
- **SHIFT**: one bit position per cycle.
- **FINISH**: the single done cycle.

Its transitions are as follows:

- **IDLE to SHIFT** (start with a legal non-zero count).
- **IDLE to FINISH** (start with count 0, or with an illegal count).
- **SHIFT to SHIFT** (more positions remain).
- **SHIFT to FINISH** (last position moved).
- **FINISH to IDLE** (always).

Top module: `acc_rshift_unit`

## Requirements
- R1: After reset the accumulator, all six flags, done and bad_count are 0. In IDLE with start low, load_en writes load_val into the accumulator and load_flags into the flags, and the new values are visible one cycle later. The load_flags bit mapping is bit0=N, bit1=Z, bit2=C, bit3=E, bit4=SV, bit5=SL.
- R2: The shift count is operand[4:0] taken as unsigned. Higher operand bits and op_is_imm have no effect on the result.
- R3: Each SHIFT cycle moves every accumulator bit one place toward bit 0 and writes 0 into bit 39. A count of k yields the loaded value shifted right logically by k. No saturation is applied.
- R4: done is high for exactly one cycle. That cycle is count+1 cycles after the cycle in which start was sampled high in IDLE. A count of 0 leaves the accumulator unchanged.
- R5: On a legal completion, N equals result bit 39 and Z is 1 exactly when all 40 result bits are 0. This also holds for a count of 0.
- R6: On a legal completion C is 0, whatever its earlier value.
- R7: On a legal completion, E is 0 when result bits 39 down to 31 are all equal, and 1 otherwise.
- R8: SV and SL change only through a load in IDLE. A shift never alters them.
- R9: A count greater than 8 moves nothing and leaves all flags unchanged. bad_count is high together with done in the cycle after start, and low at all other times.
- R10: start and load_en are ignored outside IDLE. They do not change the running shift's count, accumulator or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a shift; sampled only in IDLE |
| op_is_imm | input | 1 | Operand came from an immediate field; does not affect behaviour |
| operand | input | 16 | Operand; bits 4:0 are the shift count |
| load_en | input | 1 | Write load_val and load_flags; honoured in IDLE when start is low |
| load_val | input | 40 | Accumulator load value |
| load_flags | input | 6 | Flag load value: bit0 N, bit1 Z, bit2 C, bit3 E, bit4 SV, bit5 SL |
| acc | output | 40 | Accumulator contents |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_e | output | 1 | Extension-in-use flag |
| flag_sv | output | 1 | Sticky overflow flag (held) |
| flag_sl | output | 1 | Sticky limit flag (held) |
| done | output | 1 | One-cycle completion pulse |
| bad_count | output | 1 | Completion was for a count above 8 |

## Verification
The checks that run on every cycle are these:

- done never lasts two cycles.
- bad_count is only ever seen together with done, and the accumulator does not move in that cycle.
- Bit 39 is zero after every shift step.
- SV and SL hold whenever no load is requested.
- At each legal completion, N, Z, C and E agree with the accumulator actually presented.

The bench's scenarios are needed for the properties that depend on a history:

- the exact count+1 latency;
- whether the final value really equals the loaded value shifted by operand[4:0], whatever the upper operand bits and op_is_imm were;
- that a start or load during a running shift is dropped;
- that an illegal count keeps the flags that were previously loaded.

// File: rtl/acc_shr_pkg.sv
package acc_shr_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } shr_state_e;

    // Status flag word, N in bit 0 up to SL in bit 5
    typedef struct packed {
        logic sl;
        logic sv;
        logic e;
        logic c;
        logic z;
        logic n;
    } mac_flags_t;

    localparam int NUM_FLAGS = $bits(mac_flags_t);

endpackage

// File: rtl/shr_count_unit.sv
// Holds the remaining shift count and classifies an incoming count.
module shr_count_unit #(
    parameter int CNT_W     = 5,
    parameter int MAX_SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             cnt_zero,
    output logic             cnt_bad,
    output logic             last
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_SHIFT);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (capture) begin
            remain_q <= cnt_in;
        end else if (step && (remain_q != '0)) begin
            remain_q <= remain_q - ONE;
        end
    end

    always_comb begin
        cnt_zero = (cnt_in == '0);
        cnt_bad  = (cnt_in > LIMIT);
        last     = (remain_q == ONE);
    end

endmodule

// File: rtl/shr_acc_reg.sv
// Accumulator register with a parallel load and a one-place logical right step.
module shr_acc_reg #(
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [ACC_W-1:0] ld_val,
    input  logic             shift_en,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] acc_d
);

    logic [ACC_W-1:0] stepped;

    // Each bit takes its upper neighbour; the top bit takes zero.
    for (genvar gi = 0; gi < ACC_W; gi++) begin : g_bit
        if (gi == ACC_W - 1) begin : g_top
            assign stepped[gi] = 1'b0;
        end else begin : g_mid
            assign stepped[gi] = acc_q[gi+1];
        end
    end

    always_comb begin
        acc_d = acc_q;
        if (ld_en) begin
            acc_d = ld_val;
        end else if (shift_en) begin
            acc_d = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/shr_flag_eval.sv
// Computes N, Z and E from a candidate result value.
module shr_flag_eval #(
    parameter int ACC_W   = 40,
    parameter int GUARD_W = 8
) (
    input  logic [ACC_W-1:0] value,
    output logic             neg,
    output logic             zero,
    output logic             ext
);

    localparam int TOP = ACC_W - 1;
    localparam int LOW = ACC_W - 1 - GUARD_W;

    logic [GUARD_W:0] guard;

    always_comb begin
        guard = value[TOP:LOW];
        neg   = value[TOP];
        zero  = (value == '0);
        // Extension in use unless guard bits plus bit LOW are uniform
        ext   = !((&guard) || (~|guard));
    end

endmodule

// File: rtl/acc_rshift_unit.sv
// Iterative logical right shifter on a 40-bit accumulator with MAC flags.
module acc_rshift_unit
    import acc_shr_pkg::*;
#(
    parameter int ACC_W     = 40,
    parameter int OPND_W    = 16,
    parameter int CNT_W     = 5,
    parameter int MAX_SHIFT = 8,
    parameter int GUARD_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 op_is_imm,
    input  logic [OPND_W-1:0]    operand,
    input  logic                 load_en,
    input  logic [ACC_W-1:0]     load_val,
    input  logic [NUM_FLAGS-1:0] load_flags,
    output logic [ACC_W-1:0]     acc,
    output logic                 flag_n,
    output logic                 flag_z,
    output logic                 flag_c,
    output logic                 flag_e,
    output logic                 flag_sv,
    output logic                 flag_sl,
    output logic                 done,
    output logic                 bad_count
);

    shr_state_e       state_q;
    shr_state_e       state_d;
    mac_flags_t       flags_q;
    mac_flags_t       flags_d;
    logic [CNT_W-1:0] cnt_field;
    logic             idle;
    logic             busy;
    logic             take_start;
    logic             take_load;
    logic             shift_en;
    logic             finish_upd;
    logic             cnt_zero;
    logic             cnt_bad;
    logic             cnt_last;
    logic             bad_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic             res_n;
    logic             res_z;
    logic             res_e;
    logic             unused_opnd;

    // Count is the low field whatever the operand's origin
    assign cnt_field   = operand[CNT_W-1:0];
    assign unused_opnd = ^{operand[OPND_W-1:CNT_W], op_is_imm};

    // Controller outputs
    always_comb begin
        idle       = (state_q == ST_IDLE);
        busy       = !idle;
        take_start = idle && start;
        take_load  = idle && load_en && !start;
        shift_en   = (state_q == ST_SHIFT);
        done       = (state_q == ST_FINISH);
        finish_upd = (take_start && !cnt_bad && cnt_zero)
                   || (shift_en && cnt_last);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (cnt_bad || cnt_zero) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_SHIFT;
                    end
                end
            end
            ST_SHIFT: begin
                if (cnt_last) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    shr_count_unit #(
        .CNT_W     (CNT_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (take_start),
        .step     (shift_en),
        .cnt_in   (cnt_field),
        .cnt_zero (cnt_zero),
        .cnt_bad  (cnt_bad),
        .last     (cnt_last)
    );

    shr_acc_reg #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (take_load),
        .ld_val   (load_val),
        .shift_en (shift_en),
        .acc_q    (acc_q),
        .acc_d    (acc_d)
    );

    shr_flag_eval #(
        .ACC_W   (ACC_W),
        .GUARD_W (GUARD_W)
    ) u_flags (
        .value (acc_d),
        .neg   (res_n),
        .zero  (res_z),
        .ext   (res_e)
    );

    // Flag update: load, or completion of a legal shift
    always_comb begin
        flags_d = flags_q;
        if (take_load) begin
            flags_d = mac_flags_t'(load_flags);
        end else if (finish_upd) begin
            flags_d.n = res_n;
            flags_d.z = res_z;
            flags_d.c = 1'b0;
            flags_d.e = res_e;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            bad_q   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            bad_q   <= take_start && cnt_bad;
        end
    end

    assign acc       = acc_q;
    assign flag_n    = flags_q.n;
    assign flag_z    = flags_q.z;
    assign flag_c    = flags_q.c;
    assign flag_e    = flags_q.e;
    assign flag_sv   = flags_q.sv;
    assign flag_sl   = flags_q.sl;
    assign bad_count = bad_q;

endmodule

// File: rtl/acc_shr_checks.sv
module acc_shr_checks #(
    parameter int ACC_W   = 40,
    parameter int GUARD_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic             busy,
    input logic             done,
    input logic             bad_count,
    input logic [ACC_W-1:0] acc,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_e,
    input logic             flag_sv,
    input logic             flag_sl
);

    logic [GUARD_W:0] guard;
    assign guard = acc[ACC_W-1 -: GUARD_W+1];

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    top_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> !acc[ACC_W-1]);

    // R5
    nz_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bad_count) |-> ((flag_n == acc[ACC_W-1]) && (flag_z == (acc == '0))));

    // R6
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bad_count) |-> !flag_c);

    // R7
    ext_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bad_count) |-> (flag_e == !((&guard) || (~|guard))));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(flag_sv) && $stable(flag_sl)));

    // R9
    bad_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_count |-> done);

    // R9
    bad_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_count |-> $stable(acc));

endmodule

bind acc_rshift_unit acc_shr_checks #(
    .ACC_W   (ACC_W),
    .GUARD_W (GUARD_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .busy      (busy),
    .done      (done),
    .bad_count (bad_count),
    .acc       (acc),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_e    (flag_e),
    .flag_sv   (flag_sv),
    .flag_sl   (flag_sl)
);

// File: tb/acc_rshift_unit_test.sv
`timescale 1ns/1ps
module acc_rshift_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_is_imm = 1'b0;
    logic [15:0] operand = '0;
    logic        load_en = 1'b0;
    logic [39:0] load_val = '0;
    logic [5:0]  load_flags = '0;
    logic [39:0] acc;
    logic        flag_n, flag_z, flag_c, flag_e, flag_sv, flag_sl;
    logic        done, bad_count;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    acc_rshift_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_is_imm(op_is_imm),
        .operand(operand), .load_en(load_en), .load_val(load_val),
        .load_flags(load_flags), .acc(acc), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_e(flag_e), .flag_sv(flag_sv), .flag_sl(flag_sl),
        .done(done), .bad_count(bad_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge
    logic [39:0] m_acc;
    logic m_n, m_z, m_c, m_e, m_sv, m_sl, m_bad;
    int   m_phase;   // 0 idle, 1 shifting, 2 finishing
    int   m_rem;
    int   m_cnt;

    function automatic bit ext_of(input logic [39:0] v);
        return !((v[39:31] == 9'h1FF) || (v[39:31] == 9'h000));
    endfunction

    task automatic m_apply();
        m_n = m_acc[39];
        m_z = (m_acc == 40'd0);
        m_c = 1'b0;
        m_e = ext_of(m_acc);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0; {m_n, m_z, m_c, m_e, m_sv, m_sl} = '0;
            m_bad = 0; m_phase = 0; m_rem = 0;
        end else begin
            case (m_phase)
                0: begin
                    if (start) begin
                        m_cnt = int'(operand[4:0]);
                        if (m_cnt > 8) begin
                            m_bad = 1; m_phase = 2;
                        end else if (m_cnt == 0) begin
                            m_apply(); m_phase = 2;
                        end else begin
                            m_rem = m_cnt; m_phase = 1;
                        end
                    end else if (load_en) begin
                        m_acc = load_val;
                        m_n = load_flags[0]; m_z = load_flags[1]; m_c = load_flags[2];
                        m_e = load_flags[3]; m_sv = load_flags[4]; m_sl = load_flags[5];
                    end
                end
                1: begin
                    m_acc = m_acc >> 1;
                    m_rem--;
                    if (m_rem == 0) begin
                        m_apply(); m_phase = 2;
                    end
                end
                default: begin
                    m_phase = 0; m_bad = 0;
                end
            endcase
        end
    end

    // Per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(acc == m_acc, "R3", "acc", acc, m_acc);
            check(flag_n == m_n && flag_z == m_z, "R5", "N/Z", {38'd0, flag_n, flag_z}, {38'd0, m_n, m_z});
            check(flag_c == m_c, "R6", "C", {39'd0, flag_c}, {39'd0, m_c});
            check(flag_e == m_e, "R7", "E", {39'd0, flag_e}, {39'd0, m_e});
            check(flag_sv == m_sv && flag_sl == m_sl, "R8", "SV/SL", {38'd0, flag_sv, flag_sl}, {38'd0, m_sv, m_sl});
            check(done == (m_phase == 2), "R4", "done", {39'd0, done}, {39'd0, (m_phase == 2)});
            check(bad_count == m_bad, "R9", "bad_count", {39'd0, bad_count}, {39'd0, m_bad});
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic do_load(input logic [39:0] v, input logic [5:0] f);
        @(negedge clk);
        load_en = 1; load_val = v; load_flags = f;
        @(negedge clk);
        load_en = 0;
    endtask

    task automatic do_shift(input logic [15:0] op, input logic imm);
        @(negedge clk);
        start = 1; operand = op; op_is_imm = imm;
        @(negedge clk);
        start = 0;
        while (m_phase != 0) @(negedge clk);
    endtask

    // Start sampled, then count latency to done
    task automatic timed_shift(input logic [15:0] op, input int exp_lat, input string req);
        int lat;
        @(negedge clk);
        start = 1; operand = op;
        @(negedge clk);
        start = 0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, req, "latency", 40'(lat), 40'(exp_lat));
        @(negedge clk);
    endtask

    initial begin
        logic [39:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(acc == 0 && done == 0 && bad_count == 0, "R1", "reset acc/done", acc, 40'd0);
        check({flag_sl, flag_sv, flag_e, flag_c, flag_z, flag_n} == 6'd0, "R1", "reset flags",
              {34'd0, flag_sl, flag_sv, flag_e, flag_c, flag_z, flag_n}, 40'd0);
        rst_n = 1;

        // R1 load
        v = 40'hFF_8000_0001;
        do_load(v, 6'b111111);
        check(acc == v, "R1", "load acc", acc, v);
        check({flag_sl, flag_sv, flag_e, flag_c, flag_z, flag_n} == 6'h3F, "R1", "load flags",
              {34'd0, flag_sl, flag_sv, flag_e, flag_c, flag_z, flag_n}, 40'h3F);

        // R2 junk upper operand bits, register form: count 3
        do_shift(16'hFFE3, 1'b0);
        check(acc == (v >> 3), "R2", "count from low field", acc, v >> 3);
        check(flag_sv && flag_sl && !flag_c, "R8", "sticky kept, C cleared",
              {38'd0, flag_sv, flag_sl}, 40'd3);

        // R4 count 0 keeps value, C cleared, N from bit 39
        v = 40'h80_0000_0000;
        do_load(v, 6'b000100);
        do_shift(16'h0000, 1'b1);
        check(acc == v, "R4", "count 0 unchanged", acc, v);
        check(flag_c == 0 && flag_n == 1 && flag_e == 1, "R6", "count 0 flags",
              {37'd0, flag_c, flag_n, flag_e}, 40'd3);

        // R7 shift 8 moves bit 39 into bit 31
        do_shift(16'h0008, 1'b1);
        check(acc == 40'h00_8000_0000 && flag_e, "R7", "E after 8", acc, 40'h00_8000_0000);

        // R7 uniform guard gives E=0
        do_load(40'h00_7FFF_FFFF, 6'b001000);
        do_shift(16'h0001, 1'b0);
        check(acc == 40'h00_3FFF_FFFF && !flag_e, "R7", "E clear", acc, 40'h00_3FFF_FFFF);

        // R3 all-ones, shift 8
        do_load(40'hFF_FFFF_FFFF, 6'b000000);
        do_shift(16'h0008, 1'b1);
        check(acc == 40'h00_FFFF_FFFF, "R3", "zero fill", acc, 40'h00_FFFF_FFFF);

        // R5 zero result
        do_load(40'h00_0000_00FF, 6'b000001);
        do_shift(16'h0008, 1'b0);
        check(acc == 0 && flag_z && !flag_n, "R5", "zero result", acc, 40'd0);

        // R9 illegal counts keep state
        v = 40'h12_3456_789A;
        do_load(v, 6'b110110);
        do_shift(16'h0009, 1'b1);
        check(acc == v, "R9", "count 9 no move", acc, v);
        check({flag_sl, flag_sv, flag_e, flag_c, flag_z, flag_n} == 6'b110110, "R9", "count 9 flags",
              {34'd0, flag_sl, flag_sv, flag_e, flag_c, flag_z, flag_n}, 40'h36);
        do_shift(16'h001F, 1'b0);
        check(acc == v, "R9", "count 31 no move", acc, v);

        // R4 latencies
        timed_shift(16'h0000, 1, "R4");
        timed_shift(16'h0004, 5, "R4");
        timed_shift(16'h0009, 1, "R4");

        // R10 start and load while busy are dropped
        v = 40'hC3_A5A5_0F0F;
        do_load(v, 6'b000000);
        @(negedge clk);
        start = 1; operand = 16'h0005;
        @(negedge clk);
        start = 0;
        @(negedge clk);
        start = 1; operand = 16'h0001; load_en = 1; load_val = 40'h11_1111_1111; load_flags = 6'h3F;
        @(negedge clk);
        start = 0; load_en = 0;
        while (m_phase != 0) @(negedge clk);
        check(acc == (v >> 5), "R10", "busy start/load ignored", acc, v >> 5);
        check(!flag_sv && !flag_sl, "R10", "busy load flags ignored", {38'd0, flag_sv, flag_sl}, 40'd0);
        repeat (3) @(negedge clk);
        check(acc == (v >> 5) && !done, "R10", "no late shift", acc, v >> 5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule